// File: doc/BRIEF.md
# Four-Pin Configurable GPIO Controller with Sticky Status

The block controls four general-purpose pins through a small byte-wide register bus. Each pin has a four-bit control field. The field picks whether the pin drives or listens. For a listening pin, it also picks which input level counts as true and whether the pin reports its present condition or a latched one. For a driving pin, it picks the level to drive. Inputs are resynchronised to the local clock before any decision is made on them. The pad driver itself sits outside the block and consumes the enable and level outputs.

Software reads one status byte that carries one state bit per pin. In level mode the bit follows the conditioned input. In edge mode the bit latches any true condition and holds it until the status byte is read. The read returns the latched value and clears it in the same cycle, but a condition that is true during that cycle is captured again, so no event is lost. A suspend input, like reset, returns every control field to its own default: three listening pins, and one pin driving high. The bus is a plain strobe interface. Reads are combinational with no wait state, writes take effect at the next clock edge, and the bus has no back-pressure.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, the configuration byte at 0x59 reads 0x00 and the byte at 0x5A reads 0x90. As a result, pins 0 to 2 are active-low level-mode inputs, pin 3 drives high, pin_oe = 4'b1000 and pin_out = 4'b1000.
- R2: Pin i's control field is nibble i%2 of the byte at address 0x59 + i/2. Within a nibble, bit 0 is direction (1 = output), bit 1 is polarity (1 = active-high), bit 2 is mode (1 = edge) and bit 3 is the drive level. A write while suspend is low takes effect at the next edge, and the byte then reads back exactly as written.
- R3: pin_oe[i] equals the pin's direction bit. pin_out[i] equals the drive level when the pin is an output and is 0 when the pin is an input.
- R4: For an input pin, the synchronised input counts as true when it equals the polarity bit: a low level with polarity 0, or a high level with polarity 1.
- R5: Bit i of the status byte at 0x5B is pin i's state bit, and bits 7:4 read 0. In level mode the state bit is 1 exactly when the input is true, and a change on pin_in shows after two rising edges.
- R6: In edge mode the state bit reads 1 once the input has been true since the last status read, even if the input has since gone false.
- R7: A status read (bus_rd with address 0x5B) returns the latched value in the same cycle and clears it at the next edge. If the input is true during the read cycle, the bit stays set.
- R8: A pin configured as an output reads 0 in the status byte, and its latched flag is cleared.
- R9: While suspend is high, every control field returns to its R1 default at the next edge, writes are ignored and latched flags clear.
- R10: Reads of any address other than 0x59, 0x5A and 0x5B return 0, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend | input | 1 | Forces control defaults while high |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a status read clears latched flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 4 | Asynchronous pin inputs |
| pin_oe | output | 4 | Per-pin output enable |
| pin_out | output | 4 | Per-pin drive level |

## Verification
Each result falls due at a known cycle:

- **Input change:** a change on pin_in reaches the status byte after the second rising edge.
- **Configuration write:** a write changes pin_oe, pin_out and the readback at the first edge after the strobe.
- **Status read:** read data is valid in the strobe cycle itself, and the clearing shows from the next edge on.

The bench drives every input after a falling edge and compares read data and pin outputs just before the following rising edge. It compares them against a model that steps once per rising edge, using the inputs applied during that cycle. A directed pulse, a read while the input is still true and suspend with a concurrent write cover those cases, and random traffic covers the rest.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Control nibble, MSB first: drive level, edge mode, active-high, output
  typedef struct packed {
    logic drive_hi;
    logic edge_sel;
    logic act_high;
    logic is_output;
  } pin_cfg_t;

  localparam int          CFG_W         = 4;
  localparam int          BUS_W         = 8;
  localparam logic [7:0]  CFG_BASE_DEF  = 8'h59;
  localparam logic [7:0]  STAT_ADDR_DEF = 8'h5B;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int                      NUM_PINS = 4,
  parameter logic [BUS_W-1:0]        CFG_BASE = CFG_BASE_DEF,
  parameter logic [CFG_W*NUM_PINS-1:0] DEF_CFG = 16'h9000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        suspend,
  input  logic                        wr,
  input  logic [BUS_W-1:0]            addr,
  input  logic [BUS_W-1:0]            wdata,
  output logic [CFG_W*NUM_PINS-1:0]   cfg_flat
);
  localparam int PINS_PER_REG = BUS_W / CFG_W;
  localparam int NUM_REGS     = NUM_PINS / PINS_PER_REG;

  logic [BUS_W-1:0] reg_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [BUS_W-1:0] RA  = CFG_BASE + BUS_W'(r);
    localparam logic [BUS_W-1:0] DEF = DEF_CFG[r*BUS_W +: BUS_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   reg_q[r] <= DEF;
      else if (suspend)             reg_q[r] <= DEF;
      else if (wr && addr == RA)    reg_q[r] <= wdata;
    end

    assign cfg_flat[r*BUS_W +: BUS_W] = reg_q[r];
  end
endmodule

// File: rtl/gpio_pin_cond.sv
module gpio_pin_cond
  import gpio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     suspend,
  input  pin_cfg_t cfg,
  input  logic     sync_in,
  input  logic     stat_rd,
  output logic     stat_bit,
  output logic     oe,
  output logic     out
);
  logic true_now;
  logic listening;
  logic watch;
  logic stk_q;

  assign true_now  = ~(sync_in ^ cfg.act_high);
  assign listening = ~cfg.is_output;
  assign watch     = listening & cfg.edge_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 stk_q <= 1'b0;
    else if (suspend || !watch) stk_q <= 1'b0;
    else if (stat_rd)           stk_q <= true_now;
    else                        stk_q <= stk_q | true_now;
  end

  assign stat_bit = listening & (cfg.edge_sel ? (stk_q | true_now) : true_now);
  assign oe       = cfg.is_output;
  assign out      = cfg.is_output & cfg.drive_hi;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int                        NUM_PINS    = 4,
  parameter int                        SYNC_STAGES = 2,
  parameter logic [BUS_W-1:0]          CFG_BASE    = CFG_BASE_DEF,
  parameter logic [BUS_W-1:0]          STAT_ADDR   = STAT_ADDR_DEF,
  parameter logic [CFG_W*NUM_PINS-1:0] DEF_CFG     = 16'h9000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                suspend,
  input  logic [BUS_W-1:0]    bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out
);
  localparam int PINS_PER_REG = BUS_W / CFG_W;
  localparam int NUM_REGS     = NUM_PINS / PINS_PER_REG;

  logic [CFG_W*NUM_PINS-1:0] cfg_flat;
  logic [NUM_PINS-1:0]       in_sync;
  logic [NUM_PINS-1:0]       stat_vec;
  logic                      stat_rd;

  assign stat_rd = bus_rd && (bus_addr == STAT_ADDR);

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
  );

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .CFG_BASE(CFG_BASE), .DEF_CFG(DEF_CFG)) u_regs (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .cfg_flat(cfg_flat)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_cond u_cond (
      .clk(clk), .rst_n(rst_n), .suspend(suspend),
      .cfg(pin_cfg_t'(cfg_flat[i*CFG_W +: CFG_W])),
      .sync_in(in_sync[i]), .stat_rd(stat_rd),
      .stat_bit(stat_vec[i]), .oe(pin_oe[i]), .out(pin_out[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (bus_addr == CFG_BASE + BUS_W'(r)) bus_rdata = cfg_flat[r*BUS_W +: BUS_W];
    end
    if (bus_addr == STAT_ADDR) bus_rdata[NUM_PINS-1:0] = stat_vec;
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int                   NUM_PINS  = 4,
  parameter logic [7:0]           CFG_BASE  = 8'h59,
  parameter logic [7:0]           STAT_ADDR = 8'h5B,
  parameter logic [4*NUM_PINS-1:0] DEF_CFG  = 16'h9000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                suspend,
  input logic [7:0]          bus_addr,
  input logic                bus_wr,
  input logic [7:0]          bus_wdata,
  input logic [7:0]          bus_rdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out
);
  localparam int NUM_REGS = NUM_PINS / 2;

  function automatic logic [NUM_PINS-1:0] def_oe();
    for (int i = 0; i < NUM_PINS; i++) def_oe[i] = DEF_CFG[4*i];
  endfunction

  function automatic logic [NUM_PINS-1:0] def_out();
    for (int i = 0; i < NUM_PINS; i++) def_out[i] = DEF_CFG[4*i] & DEF_CFG[4*i+3];
  endfunction

  logic mapped;
  assign mapped = (bus_addr == STAT_ADDR) ||
                  ((bus_addr >= CFG_BASE) && (bus_addr < CFG_BASE + 8'(NUM_REGS)));

  // R3: an input pin never drives a high level
  assert_out_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R8: output pins read 0 in the status byte
  assert_stat_output_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_ADDR) |-> ((bus_rdata[NUM_PINS-1:0] & pin_oe) == '0));

  // R9: suspend restores default pin drive
  assert_suspend_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> (pin_oe == def_oe() && pin_out == def_out()));

  // R2: a write to the first control byte sets the two direction bits
  assert_write_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !suspend && bus_addr == CFG_BASE) |=>
      (pin_oe[1:0] == {$past(bus_wdata[4]), $past(bus_wdata[0])}));

  // R10: unmapped addresses read zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == 8'h00));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .CFG_BASE(CFG_BASE), .STAT_ADDR(STAT_ADDR), .DEF_CFG(DEF_CFG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .suspend(suspend), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       suspend;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] pin_in;
  logic [3:0] pin_oe;
  logic [3:0] pin_out;

  always #2 clk = ~clk;

  gpio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Model state: control nibbles, two synchroniser stages, latched flags
  logic [3:0] m_cfg [4];
  logic [3:0] m_s1, m_s2, m_stk;

  function automatic logic [3:0] dflt(input int i);
    return (i == 3) ? 4'h9 : 4'h0;
  endfunction

  function automatic logic [3:0] m_true();
    for (int i = 0; i < 4; i++) m_true[i] = (m_s2[i] == m_cfg[i][1]);
  endfunction

  function automatic logic [3:0] m_status();
    logic [3:0] t = m_true();
    for (int i = 0; i < 4; i++) begin
      if (m_cfg[i][0]) m_status[i] = 1'b0;
      else if (m_cfg[i][2]) m_status[i] = m_stk[i] | t[i];
      else m_status[i] = t[i];
    end
  endfunction

  function automatic logic [7:0] m_rdata(input logic [7:0] a);
    case (a)
      8'h59:   return {m_cfg[1], m_cfg[0]};
      8'h5A:   return {m_cfg[3], m_cfg[2]};
      8'h5B:   return {4'h0, m_status()};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] m_oe();
    for (int i = 0; i < 4; i++) m_oe[i] = m_cfg[i][0];
  endfunction

  function automatic logic [3:0] m_out();
    for (int i = 0; i < 4; i++) m_out[i] = m_cfg[i][0] & m_cfg[i][3];
  endfunction

  task automatic step(input logic [7:0] a, input logic w, input logic r,
                      input logic [7:0] d, input logic [3:0] p, input logic s,
                      input string tag);
    logic [7:0] er;
    logic [3:0] eo, ed, t;
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; pin_in = p; suspend = s;
    #1;
    er = m_rdata(a); eo = m_oe(); ed = m_out();
    n_vec++;
    if (bus_rdata !== er || pin_oe !== eo || pin_out !== ed) begin
      n_bad++;
      $display("FAIL %s addr=%h: rdata=%h oe=%h out=%h expected rdata=%h oe=%h out=%h",
               tag, a, bus_rdata, pin_oe, pin_out, er, eo, ed);
    end
    @(posedge clk);
    t = m_true();
    for (int i = 0; i < 4; i++) begin
      if (s || m_cfg[i][0] || !m_cfg[i][2]) m_stk[i] = 1'b0;
      else if (r && a == 8'h5B) m_stk[i] = t[i];
      else m_stk[i] = m_stk[i] | t[i];
    end
    if (s) begin
      for (int i = 0; i < 4; i++) m_cfg[i] = dflt(i);
    end else if (w && a == 8'h59) begin
      m_cfg[0] = d[3:0]; m_cfg[1] = d[7:4];
    end else if (w && a == 8'h5A) begin
      m_cfg[2] = d[3:0]; m_cfg[3] = d[7:4];
    end
    m_s2 = m_s1; m_s1 = p;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [3:0] p, input string tag);
    for (int k = 0; k < n; k++) step(8'h5B, 1'b0, 1'b0, 8'h00, p, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; suspend = 1'b0; bus_addr = 8'h5A; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 8'h00; pin_in = 4'hF;
    for (int i = 0; i < 4; i++) m_cfg[i] = dflt(i);
    m_s1 = '0; m_s2 = '0; m_stk = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    n_vec++;
    if (bus_rdata !== 8'h90 || pin_oe !== 4'b1000 || pin_out !== 4'b1000) begin
      n_bad++;
      $display("FAIL R1: rdata=%h oe=%h out=%h expected rdata=90 oe=8 out=8",
               bus_rdata, pin_oe, pin_out);
    end
    rst_n = 1'b1;
    step(8'h59, 1'b0, 1'b0, 8'h00, 4'hF, 1'b0, "R1");
    step(8'h5A, 1'b0, 1'b0, 8'h00, 4'hF, 1'b0, "R1");
    idle(3, 4'hF, "R5");

    // R2 and R3: write pin0 output high, pin1 active-high level input
    step(8'h59, 1'b1, 1'b0, 8'h29, 4'hF, 1'b0, "R2");
    step(8'h59, 1'b0, 1'b0, 8'h00, 4'hF, 1'b0, "R2");
    step(8'h59, 1'b1, 1'b0, 8'h21, 4'hF, 1'b0, "R3");
    step(8'h59, 1'b0, 1'b0, 8'h00, 4'hF, 1'b0, "R3");

    // R4 and R5: toggle pin1, watch the two-edge delay
    step(8'h5B, 1'b0, 1'b0, 8'h00, 4'hD, 1'b0, "R4");
    step(8'h5B, 1'b0, 1'b0, 8'h00, 4'hD, 1'b0, "R5");
    step(8'h5B, 1'b0, 1'b0, 8'h00, 4'hD, 1'b0, "R5");
    step(8'h5B, 1'b0, 1'b0, 8'h00, 4'hF, 1'b0, "R4");
    idle(3, 4'hF, "R5");

    // R6: pin2 active-high edge input, single-cycle pulse
    step(8'h5A, 1'b1, 1'b0, 8'h96, 4'hB, 1'b0, "R6");
    idle(3, 4'hB, "R6");
    step(8'h5B, 1'b0, 1'b0, 8'h00, 4'hF, 1'b0, "R6");
    idle(5, 4'hB, "R6");
    // R7: read clears, next read shows 0
    step(8'h5B, 1'b0, 1'b1, 8'h00, 4'hB, 1'b0, "R7");
    step(8'h5B, 1'b0, 1'b0, 8'h00, 4'hB, 1'b0, "R7");
    // R7: read while the input is still true keeps the flag
    idle(3, 4'hF, "R7");
    step(8'h5B, 1'b0, 1'b1, 8'h00, 4'hF, 1'b0, "R7");
    step(8'h5B, 1'b0, 1'b1, 8'h00, 4'hB, 1'b0, "R7");
    idle(3, 4'hB, "R7");

    // R8: make pin2 an output, status must read 0
    step(8'h5A, 1'b1, 1'b0, 8'h97, 4'hF, 1'b0, "R8");
    idle(3, 4'hF, "R8");

    // R9: suspend with a concurrent write
    step(8'h59, 1'b1, 1'b0, 8'h11, 4'h0, 1'b1, "R9");
    step(8'h59, 1'b1, 1'b0, 8'h11, 4'h0, 1'b1, "R9");
    step(8'h5A, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, "R9");
    step(8'h59, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, "R9");

    // R10: unmapped read and write
    step(8'h00, 1'b1, 1'b0, 8'hFF, 4'h0, 1'b0, "R10");
    step(8'h58, 1'b1, 1'b0, 8'hFF, 4'h0, 1'b0, "R10");
    step(8'h59, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, "R10");
    step(8'h5A, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, "R10");

    // Random traffic, checked against the model
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = 8'h59;
        1: a = 8'h5A;
        2: a = 8'h5B;
        default: a = 8'($urandom);
      endcase
      step(a, ($urandom_range(0, 5) == 0), ($urandom_range(0, 2) == 0), 8'($urandom),
           4'($urandom), ($urandom_range(0, 60) == 0), "R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule